// File: doc/BRIEF.md
# Three-Phase Gate Control Core

This block is the digital heart of a three-phase half-bridge gate driver. For each of the three phases it receives two active-low PWM requests, one for the upper switch and one for the lower. It produces two active-high gate enables per phase. Every request first passes a glitch filter. The two switches of a phase are kept mutually exclusive, and a gap is enforced between one switch of a phase releasing and its partner engaging.

Protection comes from two inputs. The over-current input is blanked for a short window so that a switching spike does not trip the bridge. A sustained trip latches a fault that disables all six gates at once. The undervoltage flag disables the gates only while it is present. Either condition drives an open-drain fault pin, modelled here as an output enable that pulls the pin low. A latched over-current fault is released through the lower-side requests: they must all sit idle for a fixed, long clear interval. All times are counted in clock cycles and set by parameters.

Top module: `bridge_gate_ctl`

## Requirements
- R1: Inverted sense. A gate output (`ho[p]` for `hin_n[p]`, `lo[p]` for `lin_n[p]`) is high only while its request input is held low (0 = request on). Releasing the input to 1 turns the gate off.
- R2: `ho[p]` and `lo[p]` are never both 1. If both inputs of a phase request on, both outputs of that phase go to 0.
- R3: A gate of a phase turns on no sooner than DEAD_CYC clock cycles after its partner gate turned off. An on-request that arrives during that gap is held and then granted, with a gap of DEAD_CYC+1 cycles.
- R4: A level change on any of the six request inputs lasting fewer than FILT_CYC clock cycles has no effect on the outputs. A change held for FILT_CYC cycles is accepted.
- R5: `itrip` (1 = over-current) held for BLANK_CYC cycles or fewer sets no fault. Held continuously, it raises `flt_oe` BLANK_CYC+2 cycles after it rises.
- R6: While `flt_oe` is 1, all six outputs are 0 from the next cycle on, whatever the request inputs do.
- R7: While `uv` is 1, the outputs are off and `flt_oe` is 1. When `uv` returns to 0, the outputs follow their requests again without any clear procedure.
- R8: `flt_oe` is 1 one cycle after `uv` is 1, and it stays 1 for as long as an over-current fault is latched.
- R9: A latched over-current fault clears only after `itrip` is 0 and all three `lin_n` inputs have been held at 1 for CLR_CYC consecutive cycles. Any lower-side on-request during the fault restarts that interval.
- R10: Input-to-output latency is the same for all six channels: FILT_CYC+2 cycles from an input change to the gate change when no gap or fault holds it back.
- R11: A synchronous active-low reset forces all six outputs and `flt_oe` to 0 and clears the fault latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hin_n | input | 3 | Upper-switch requests, active low, one bit per phase |
| lin_n | input | 3 | Lower-switch requests, active low, one bit per phase |
| itrip | input | 1 | Over-current trip, active high |
| uv | input | 1 | Undervoltage flag, active high |
| ho | output | 3 | Upper gate enables, active high |
| lo | output | 3 | Lower gate enables, active high |
| flt_oe | output | 1 | Fault pin pull-down enable; 1 pulls the open-drain pin low |

## Verification
The properties assume that every input is already synchronous to `clk` and changes only between edges. They also assume that `itrip` stays at one clean level within each cycle, because the blanking property counts consecutive high samples of `itrip` in the same way the block does. The bench meets these assumptions by changing every input on the falling clock edge. It keeps `uv` and `itrip` as plain levels held for whole cycles, and it releases reset only while all requests are idle.

// File: rtl/bridge_gate_ctl.sv
module bridge_gate_ctl #(
  parameter int FILT_CYC  = 88,
  parameter int DEAD_CYC  = 500,
  parameter int BLANK_CYC = 100,
  parameter int CLR_CYC   = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hin_n,
  input  logic [2:0] lin_n,
  input  logic       itrip,
  input  logic       uv,
  output logic [2:0] ho,
  output logic [2:0] lo,
  output logic       flt_oe
);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int CW = $clog2(CLR_CYC + 1);

  logic [5:0] in_s, in_f;
  logic       itrip_s, uv_s, oc_q;
  logic [BW-1:0] tcnt;
  logic [CW-1:0] ccnt;
  logic [2:0] hreq, lreq;
  logic       run, lows_idle, trip_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_s    <= '1;
      itrip_s <= 1'b0;
      uv_s    <= 1'b0;
    end else begin
      in_s    <= {lin_n, hin_n};
      itrip_s <= itrip;
      uv_s    <= uv;
    end
  end

  for (genvar i = 0; i < 6; i++) begin : g_filt
    logic          f_q;
    logic [FW-1:0] c_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f_q <= 1'b1;
        c_q <= '0;
      end else if (in_s[i] == f_q) begin
        c_q <= '0;
      end else if (c_q == FW'(FILT_CYC - 1)) begin
        f_q <= in_s[i];
        c_q <= '0;
      end else begin
        c_q <= c_q + FW'(1);
      end
    end
    assign in_f[i] = f_q;
  end

  assign hreq      = ~in_f[2:0];
  assign lreq      = ~in_f[5:3];
  assign run       = ~oc_q & ~uv_s;
  assign lows_idle = &in_f[5:3];
  assign trip_hit  = itrip_s & (tcnt == BW'(BLANK_CYC));

  for (genvar p = 0; p < 3; p++) begin : g_ph
    logic          h_q, l_q;
    logic [DW-1:0] hoff, loff;
    logic          h_ok, l_ok;
    assign h_ok = ~l_q & (loff == DW'(DEAD_CYC));
    assign l_ok = ~h_q & (hoff == DW'(DEAD_CYC));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        h_q  <= 1'b0;
        l_q  <= 1'b0;
        hoff <= DW'(DEAD_CYC);
        loff <= DW'(DEAD_CYC);
      end else begin
        h_q <= run & hreq[p] & ~lreq[p] & h_ok;
        l_q <= run & lreq[p] & ~hreq[p] & l_ok;
        if (h_q)                           hoff <= '0;
        else if (hoff != DW'(DEAD_CYC))    hoff <= hoff + DW'(1);
        if (l_q)                           loff <= '0;
        else if (loff != DW'(DEAD_CYC))    loff <= loff + DW'(1);
      end
    end
    assign ho[p] = h_q;
    assign lo[p] = l_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= '0;
      ccnt <= '0;
      oc_q <= 1'b0;
    end else begin
      if (!itrip_s)                     tcnt <= '0;
      else if (tcnt != BW'(BLANK_CYC))  tcnt <= tcnt + BW'(1);
      if (oc_q) begin
        if (itrip_s || !lows_idle) begin
          ccnt <= '0;
        end else if (ccnt == CW'(CLR_CYC - 1)) begin
          ccnt <= '0;
          oc_q <= 1'b0;
        end else begin
          ccnt <= ccnt + CW'(1);
        end
      end else if (trip_hit) begin
        oc_q <= 1'b1;
      end
    end
  end

  assign flt_oe = oc_q | uv_s;
endmodule

// File: rtl/bridge_gate_ctl_chk.sv
module bridge_gate_ctl_chk #(
  parameter int DEAD_CYC  = 500,
  parameter int BLANK_CYC = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       itrip,
  input logic       uv,
  input logic [2:0] ho,
  input logic [2:0] lo,
  input logic       flt_oe
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int TW = $clog2(BLANK_CYC + 2);

  logic [TW-1:0] trip_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                           trip_run <= '0;
    else if (!itrip)                      trip_run <= '0;
    else if (trip_run != TW'(BLANK_CYC + 1)) trip_run <= trip_run + TW'(1);
  end

  for (genvar p = 0; p < 3; p++) begin : g_chk
    logic [DW-1:0] hlow, llow;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hlow <= DW'(DEAD_CYC);
        llow <= DW'(DEAD_CYC);
      end else begin
        if (ho[p])                        hlow <= '0;
        else if (hlow != DW'(DEAD_CYC))   hlow <= hlow + DW'(1);
        if (lo[p])                        llow <= '0;
        else if (llow != DW'(DEAD_CYC))   llow <= llow + DW'(1);
      end
    end

    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(ho[p] && lo[p]));
    a_r3_gap_high: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ho[p]) |-> (llow >= DW'(DEAD_CYC)));
    a_r3_gap_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo[p]) |-> (hlow >= DW'(DEAD_CYC)));
  end

  a_r6_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flt_oe |=> (ho == 3'b000 && lo == 3'b000));
  a_r5_blank_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flt_oe) && !$past(uv)) |-> ($past(trip_run) > TW'(BLANK_CYC)));
  a_r8_uv_flag: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> flt_oe);
endmodule

bind bridge_gate_ctl bridge_gate_ctl_chk #(.DEAD_CYC(DEAD_CYC), .BLANK_CYC(BLANK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .itrip(itrip), .uv(uv),
  .ho(ho), .lo(lo), .flt_oe(flt_oe)
);

// File: tb/sim_bridge_gate_ctl.sv
`timescale 1ns/1ps
module sim_bridge_gate_ctl;
  localparam int FILT  = 4;
  localparam int DEAD  = 10;
  localparam int BLANK = 6;
  localparam int CLR   = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hin_n = 3'b111;
  logic [2:0] lin_n = 3'b111;
  logic itrip = 1'b0;
  logic uv = 1'b0;
  logic [2:0] ho, lo;
  logic flt_oe;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int overlaps = 0;
  int gap_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_gate_ctl #(.FILT_CYC(FILT), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .CLR_CYC(CLR)) u0 (
    .clk(clk), .rst_n(rst_n), .hin_n(hin_n), .lin_n(lin_n), .itrip(itrip), .uv(uv),
    .ho(ho), .lo(lo), .flt_oe(flt_oe)
  );

  int   hfall [3] = '{-100000, -100000, -100000};
  int   lfall [3] = '{-100000, -100000, -100000};
  logic [2:0] ho_p = 3'b000, lo_p = 3'b000;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int p = 0; p < 3; p++) begin
      if (ho[p] && lo[p]) overlaps++;
      if (ho_p[p] && !ho[p]) hfall[p] = cyc;
      if (lo_p[p] && !lo[p]) lfall[p] = cyc;
      if (ho[p] && !ho_p[p] && (cyc - lfall[p] < DEAD)) gap_bad++;
      if (lo[p] && !lo_p[p] && (cyc - hfall[p] < DEAD)) gap_bad++;
    end
    ho_p = ho;
    lo_p = lo;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(3);
    chk(ho == 0 && lo == 0 && flt_oe == 0, "R11 reset state", {ho, lo, flt_oe}, 0);
    rst_n = 1'b1;
    step(2);
    chk(ho == 0 && lo == 0 && flt_oe == 0, "R11 after release", {ho, lo, flt_oe}, 0);
  endtask

  task automatic t_invert;
    for (int p = 0; p < 3; p++) begin
      hin_n[p] = 1'b0;
      step(FILT + 3);
      chk(ho[p] == 1 && lo == 0, "R1 high gate follows low input", ho[p], 1);
      hin_n[p] = 1'b1;
      step(FILT + 3);
      chk(ho[p] == 0, "R1 high gate off on released input", ho[p], 0);
    end
    step(DEAD + 4);
    for (int p = 0; p < 3; p++) begin
      lin_n[p] = 1'b0;
      step(FILT + 3);
      chk(lo[p] == 1 && ho == 0, "R1 low gate follows low input", lo[p], 1);
      lin_n[p] = 1'b1;
      step(FILT + 3);
      chk(lo[p] == 0, "R1 low gate off on released input", lo[p], 0);
    end
    step(DEAD + 4);
  endtask

  task automatic t_latency;
    int lat [6];
    for (int ch = 0; ch < 6; ch++) begin
      if (ch < 3) hin_n[ch] = 1'b0; else lin_n[ch-3] = 1'b0;
      lat[ch] = -1;
      for (int k = 1; k <= 40; k++) begin
        step(1);
        if (lat[ch] < 0 && ((ch < 3) ? ho[ch] : lo[ch-3])) lat[ch] = k;
      end
      hin_n = 3'b111;
      lin_n = 3'b111;
      step(FILT + DEAD + 6);
      chk(lat[ch] == FILT + 2, "R10 channel latency", lat[ch], FILT + 2);
    end
  endtask

  task automatic t_overlap;
    hin_n[1] = 1'b0;
    step(FILT + 3);
    chk(ho[1] == 1, "R2 high gate on before conflict", ho[1], 1);
    lin_n[1] = 1'b0;
    step(FILT + 3);
    chk(ho[1] == 0 && lo[1] == 0, "R2 both requested gives both off", {ho[1], lo[1]}, 0);
    step(2 * DEAD);
    chk(ho[1] == 0 && lo[1] == 0, "R2 both off while conflict held", {ho[1], lo[1]}, 0);
    hin_n = 3'b111;
    lin_n = 3'b111;
    step(FILT + DEAD + 6);
  endtask

  task automatic t_dead;
    int kf, kr;
    lin_n[2] = 1'b0;
    step(FILT + 3);
    chk(lo[2] == 1, "R3 low gate on", lo[2], 1);
    lin_n[2] = 1'b1;
    hin_n[2] = 1'b0;
    kf = -1; kr = -1;
    for (int k = 1; k <= FILT + DEAD + 10; k++) begin
      step(1);
      if (kf < 0 && !lo[2]) kf = k;
      if (kr < 0 && ho[2]) kr = k;
      if (k == FILT + 2 + DEAD / 2)
        chk(ho[2] == 0, "R3 request held during gap", ho[2], 0);
    end
    chk(kr - kf >= DEAD && kr - kf <= DEAD + 1, "R3 gap low to high", kr - kf, DEAD + 1);
    hin_n[2] = 1'b1;
    lin_n[2] = 1'b0;
    kf = -1; kr = -1;
    for (int k = 1; k <= FILT + DEAD + 10; k++) begin
      step(1);
      if (kf < 0 && !ho[2]) kf = k;
      if (kr < 0 && lo[2]) kr = k;
    end
    chk(kr - kf >= DEAD && kr - kf <= DEAD + 1, "R3 gap high to low", kr - kf, DEAD + 1);
    lin_n = 3'b111;
    step(FILT + DEAD + 6);
  endtask

  task automatic t_filter;
    int seen;
    hin_n[0] = 1'b0;
    step(FILT - 1);
    hin_n[0] = 1'b1;
    seen = 0;
    for (int k = 0; k < FILT + 6; k++) begin step(1); if (ho[0]) seen++; end
    chk(seen == 0, "R4 short on-pulse rejected", seen, 0);
    hin_n[0] = 1'b0;
    step(FILT);
    hin_n[0] = 1'b1;
    seen = 0;
    for (int k = 0; k < FILT + 6; k++) begin step(1); if (ho[0]) seen++; end
    chk(seen > 0, "R4 pulse of filter length accepted", seen, FILT);
    step(DEAD);
    hin_n[0] = 1'b0;
    step(FILT + 3);
    hin_n[0] = 1'b1;
    step(FILT - 1);
    hin_n[0] = 1'b0;
    seen = 0;
    for (int k = 0; k < FILT + 6; k++) begin step(1); if (!ho[0]) seen++; end
    chk(seen == 0, "R4 short off-pulse rejected", seen, 0);
    hin_n[0] = 1'b1;
    step(FILT + DEAD + 6);
  endtask

  task automatic t_blank;
    int seen;
    itrip = 1'b1;
    step(BLANK);
    itrip = 1'b0;
    seen = 0;
    for (int k = 0; k < 2 * BLANK + 4; k++) begin step(1); if (flt_oe) seen++; end
    chk(seen == 0, "R5 trip within blanking ignored", seen, 0);
  endtask

  task automatic t_trip_clear;
    int kt, bad;
    hin_n[0] = 1'b0;
    lin_n[1] = 1'b0;
    step(FILT + 3);
    chk(ho[0] == 1 && lo[1] == 1, "R6 gates on before trip", {ho[0], lo[1]}, 3);
    itrip = 1'b1;
    kt = -1;
    for (int k = 1; k <= BLANK + 6; k++) begin
      step(1);
      if (kt < 0 && flt_oe) kt = k;
    end
    chk(kt == BLANK + 2, "R5 trip delay to fault", kt, BLANK + 2);
    chk(ho == 0 && lo == 0, "R6 all gates off on trip", {ho, lo}, 0);
    itrip = 1'b0;
    bad = 0;
    for (int k = 0; k < 3 * CLR; k++) begin
      step(1);
      if (!flt_oe || ho != 0 || lo != 0) bad++;
    end
    chk(bad == 0, "R9 low-side request blocks clear", bad, 0);
    chk(flt_oe == 1, "R8 fault held while latched", flt_oe, 1);
    hin_n = 3'b111;
    lin_n = 3'b111;
    step(CLR);
    chk(flt_oe == 1, "R9 fault still set before clear time", flt_oe, 1);
    step(FILT + 4);
    chk(flt_oe == 0, "R9 fault cleared after idle interval", flt_oe, 0);
    hin_n[0] = 1'b0;
    step(FILT + 3);
    chk(ho[0] == 1, "R9 gates resume after clear", ho[0], 1);
  endtask

  task automatic t_uv;
    uv = 1'b1;
    step(1);
    chk(flt_oe == 1, "R8 fault pin on undervoltage", flt_oe, 1);
    step(1);
    chk(ho == 0 && lo == 0, "R7 gates off on undervoltage", {ho, lo}, 0);
    step(10);
    chk(ho == 0 && flt_oe == 1, "R7 held off during undervoltage", {ho, flt_oe}, 1);
    uv = 1'b0;
    step(2);
    chk(ho[0] == 1 && flt_oe == 0, "R7 resume without clear", {ho[0], flt_oe}, 2);
    hin_n = 3'b111;
    step(FILT + DEAD + 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_invert();
    t_latency();
    t_overlap();
    t_dead();
    t_filter();
    t_blank();
    t_trip_clear();
    t_uv();
    chk(overlaps == 0, "R2 no overlap seen by monitor", overlaps, 0);
    chk(gap_bad == 0, "R3 gap never short in monitor", gap_bad, 0);
    summary();
    $finish;
  end
endmodule